// File: doc/BRIEF.md
# TDM Time-Slot Bit Selector

This block sits between a serial time-division-multiplexed highway and a byte-oriented framer. On the receive side it locates one programmable time slot in every frame, collects the eight bit times of that slot, discards the positions the mask excludes, and hands the framer one byte per frame. On the transmit side it takes one byte from the framer per frame and drives its unmasked bits into the same kind of slot. Between those bits the data pin is released, and an output-enable flags this for the pad. The two directions share the serial clock and frame sync but have separate placement, mask, bit-order and clock-edge settings.

A frame begins at the bit time in which frame sync is first seen active. The slot begins a programmable number of whole slots plus a fine number of bit times later. Masking single bit positions of the slot gives net rates from one to eight bits per frame, which is 8 to 64 kbit/s at an 8 kHz frame rate. With highway mode off, the block streams every bit and ignores sync and masks. The serial clock is sampled by the system clock, so it must run below half the system clock rate.

Top module: `tdm_slot_sel`

## Requirements
- R1: Frame sync is taken on each direction's own active edge. It is active high when `fs_pol`=0 and active low when `fs_pol`=1. The bit time in which it is first seen active, after being inactive, is bit time 0 of a new frame, and the bit counters restart there.
- R2: In highway mode the slot occupies bit times S to S+7 of the frame, where S = 8*slot_off + bit_off, set separately for each direction.
- R3: Bit position p of the byte (0..7) carries data only when mask[p]=1. A masked receive position reads as 0 in `rx_byte`. A masked transmit position leaves `tx_oe` low.
- R4: With lsb_first=1 the k-th bit of the slot (k=0..7) is byte bit k. With lsb_first=0 it is byte bit 7-k.
- R5: With edge_inv=0 transmit data launches on the falling serial-clock edge and receive data and sync are sampled on the rising edge. With edge_inv=1 the two edges swap.
- R6: In highway mode `tx_slot_act` is high for all eight bit times of the transmit slot, masked or not, and low elsewhere. It is low after reset.
- R7: `tx_oe` is high only for unmasked transmit slot bits in highway mode. Whenever `tx_oe` is low, `tx_sd` is 0. Both are low after reset.
- R8: `tx_take` pulses for one system clock when the first slot bit launches, and `tx_byte` is captured then. `rx_valid` pulses for one clock with `rx_byte` after the eighth slot bit is sampled. Each happens once per frame that contains the whole slot.
- R9: With `hwy_en`=0 every bit time carries data, in bytes counted from the first edge after reset. Frame sync and masks have no effect, `tx_oe` stays high and `tx_slot_act` stays low.
- R10: The transmit outputs change only after a transmit launch edge, at most three system clocks later, and stay steady across the receive edge. `rx_valid` follows a receive sample edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwy_en | input | 1 | 1: slot selection on; 0: continuous streaming |
| fs_pol | input | 1 | Frame sync polarity, 1 = active low |
| tx_edge_inv | input | 1 | Transmit launch edge select |
| rx_edge_inv | input | 1 | Receive sample edge select |
| tx_lsb_first | input | 1 | Transmit bit order |
| rx_lsb_first | input | 1 | Receive bit order |
| tx_bit_off | input | 3 | Transmit fine bit offset |
| tx_slot_off | input | SLOT_W | Transmit slot offset |
| tx_mask | input | 8 | Transmit bit-position mask |
| rx_bit_off | input | 3 | Receive fine bit offset |
| rx_slot_off | input | SLOT_W | Receive slot offset |
| rx_mask | input | 8 | Receive bit-position mask |
| sclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync |
| rx_sd | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte from the framer to send |
| tx_sd | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit data drive enable |
| tx_slot_act | output | 1 | Transmit slot window marker |
| tx_take | output | 1 | Pulse: `tx_byte` captured |
| rx_byte | output | 8 | Received slot byte |
| rx_valid | output | 1 | Pulse: `rx_byte` is new |

## Verification
Frames are driven with whole-slot placement, with fine offsets that make a slot straddle a slot boundary, and with a frame only as long as the slot needs, so a wrong start position or a counter that does not restart at sync shows up as shifted bits. Sparse masks with different bit orders in the two directions tell a mask indexed by slot bit time apart from one indexed by byte position. An inverted-polarity sync and a run with both clock edges swapped show whether sync and data are taken on the configured edge. A streaming run with sync pulses and a partial mask still applied shows whether either leaks into non-highway mode.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;

    localparam int LANE_W = 8;
    localparam int IDX_W  = $clog2(LANE_W);

    // One event per serial edge of a direction, as seen by a lane
    typedef struct packed {
        logic             tick;   // active edge of this direction
        logic             hit;    // edge falls inside the selected slot
        logic             first;  // first bit time of the slot
        logic             last;   // last bit time of the slot
        logic [IDX_W-1:0] pos;    // byte bit position after order mapping
    } slot_evt_t;

    // Map the k-th bit time of a slot onto a byte bit position
    function automatic logic [IDX_W-1:0] lane_pos(input logic [IDX_W-1:0] idx,
                                                  input logic             lsb_first);
        logic [IDX_W-1:0] top_idx;
        top_idx = IDX_W'(LANE_W - 1);
        return lsb_first ? idx : (top_idx - idx);
    endfunction

endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic fsync,
    input  logic sdata,
    output logic fs_s,
    output logic sd_s,
    output logic rise,
    output logic fall
);
    localparam int WARM   = STAGES + 1;
    localparam int WARM_W = $clog2(WARM + 1);

    typedef struct packed {
        logic [STAGES-1:0] ck;
        logic [STAGES-1:0] fs;
        logic [STAGES-1:0] sd;
        logic              ck_prev;
        logic [WARM_W-1:0] warm;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     ready;

    always_comb begin
        st_d         = st_q;
        st_d.ck      = {st_q.ck[STAGES-2:0], sclk};
        st_d.fs      = {st_q.fs[STAGES-2:0], fsync};
        st_d.sd      = {st_q.sd[STAGES-2:0], sdata};
        st_d.ck_prev = st_q.ck[STAGES-1];
        ready        = (st_q.warm == WARM_W'(WARM));
        if (!ready) begin
            st_d.warm = st_q.warm + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // All three inputs pass through the same depth, so they stay aligned
    assign fs_s = st_q.fs[STAGES-1];
    assign sd_s = st_q.sd[STAGES-1];
    assign rise = ready &  st_q.ck[STAGES-1] & ~st_q.ck_prev;
    assign fall = ready & ~st_q.ck[STAGES-1] &  st_q.ck_prev;

endmodule

// File: rtl/tdm_slot_locator.sv
module tdm_slot_locator
    import tdm_sel_pkg::*;
#(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fs_act,
    input  logic              hwy_en,
    input  logic              lsb_first,
    input  logic [IDX_W-1:0]  bit_off,
    input  logic [SLOT_W-1:0] slot_off,
    output slot_evt_t         evt
);
    localparam int CNT_W = SLOT_W + IDX_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fs_prev;
    } loc_st_t;

    loc_st_t          st_d, st_q;
    logic             fs_start;
    logic [CNT_W-1:0] cnt_now;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] rel;
    logic             in_win;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d     = st_q;
        fs_start = hwy_en & fs_act & ~st_q.fs_prev;
        start    = CNT_W'({slot_off, bit_off});

        cnt_now = '0;
        if (!hwy_en) begin
            cnt_now[IDX_W-1:0] = st_q.cnt[IDX_W-1:0] + 1'b1;
        end else if (fs_start) begin
            cnt_now = '0;
        end else if (st_q.cnt == CNT_MAX) begin
            cnt_now = CNT_MAX;
        end else begin
            cnt_now = st_q.cnt + 1'b1;
        end

        rel = cnt_now - start;
        if (hwy_en) begin
            in_win = (cnt_now >= start) && (rel < CNT_W'(LANE_W));
            idx    = rel[IDX_W-1:0];
        end else begin
            in_win = 1'b1;
            idx    = cnt_now[IDX_W-1:0];
        end

        evt.tick  = tick;
        evt.hit   = tick & in_win;
        evt.first = (idx == '0);
        evt.last  = (idx == IDX_W'(LANE_W - 1));
        evt.pos   = lane_pos(idx, lsb_first);

        if (tick) begin
            st_d.cnt     = cnt_now;
            st_d.fs_prev = fs_act;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt     <= CNT_MAX;
            st_q.fs_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
    import tdm_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_evt_t         evt,
    input  logic              sd,
    input  logic              hwy_en,
    input  logic [LANE_W-1:0] mask,
    output logic [LANE_W-1:0] rx_byte,
    output logic              rx_valid
);
    typedef struct packed {
        logic [LANE_W-1:0] acc;
        logic [LANE_W-1:0] data;
        logic              valid;
    } rx_st_t;

    rx_st_t            st_d, st_q;
    logic [LANE_W-1:0] acc_new;
    logic              bit_v;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        acc_new    = evt.first ? '0 : st_q.acc;
        bit_v      = sd & (mask[evt.pos] | ~hwy_en);
        acc_new[evt.pos] = bit_v;
        if (evt.tick && evt.hit) begin
            st_d.acc = acc_new;
            if (evt.last) begin
                st_d.data  = acc_new;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_byte  = st_q.data;
    assign rx_valid = st_q.valid;

endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
    import tdm_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slot_evt_t         evt,
    input  logic              hwy_en,
    input  logic [LANE_W-1:0] mask,
    input  logic [LANE_W-1:0] tx_byte,
    output logic              tx_sd,
    output logic              tx_oe,
    output logic              tx_slot_act,
    output logic              tx_take
);
    typedef struct packed {
        logic [LANE_W-1:0] hold;
        logic              sd;
        logic              oe;
        logic              act;
        logic              take;
    } tx_st_t;

    tx_st_t            st_d, st_q;
    logic [LANE_W-1:0] cur;
    logic              live;

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        cur       = evt.first ? tx_byte : st_q.hold;
        live      = mask[evt.pos] | ~hwy_en;
        if (evt.tick) begin
            if (evt.hit) begin
                if (evt.first) begin
                    st_d.hold = tx_byte;
                    st_d.take = 1'b1;
                end
                st_d.oe  = live;
                st_d.sd  = live & cur[evt.pos];
                st_d.act = hwy_en;
            end else begin
                st_d.oe  = 1'b0;
                st_d.sd  = 1'b0;
                st_d.act = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_sd       = st_q.sd;
    assign tx_oe       = st_q.oe;
    assign tx_slot_act = st_q.act;
    assign tx_take     = st_q.take;

endmodule

// File: rtl/tdm_slot_sel.sv
module tdm_slot_sel
    import tdm_sel_pkg::*;
#(
    parameter int SLOT_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hwy_en,
    input  logic              fs_pol,
    input  logic              tx_edge_inv,
    input  logic              rx_edge_inv,
    input  logic              tx_lsb_first,
    input  logic              rx_lsb_first,
    input  logic [2:0]        tx_bit_off,
    input  logic [SLOT_W-1:0] tx_slot_off,
    input  logic [7:0]        tx_mask,
    input  logic [2:0]        rx_bit_off,
    input  logic [SLOT_W-1:0] rx_slot_off,
    input  logic [7:0]        rx_mask,
    input  logic              sclk,
    input  logic              fsync,
    input  logic              rx_sd,
    input  logic [7:0]        tx_byte,
    output logic              tx_sd,
    output logic              tx_oe,
    output logic              tx_slot_act,
    output logic              tx_take,
    output logic [7:0]        rx_byte,
    output logic              rx_valid
);
    logic      fs_s, sd_s, ck_rise, ck_fall;
    logic      fs_act;
    logic      tx_tick, rx_tick;
    slot_evt_t tx_evt, rx_evt;

    tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .fsync (fsync),
        .sdata (rx_sd),
        .fs_s  (fs_s),
        .sd_s  (sd_s),
        .rise  (ck_rise),
        .fall  (ck_fall)
    );

    assign fs_act  = fs_s ^ fs_pol;
    assign tx_tick = tx_edge_inv ? ck_rise : ck_fall;
    assign rx_tick = rx_edge_inv ? ck_fall : ck_rise;

    tdm_slot_locator #(.SLOT_W(SLOT_W)) u_tx_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tx_tick),
        .fs_act    (fs_act),
        .hwy_en    (hwy_en),
        .lsb_first (tx_lsb_first),
        .bit_off   (tx_bit_off),
        .slot_off  (tx_slot_off),
        .evt       (tx_evt)
    );

    tdm_slot_locator #(.SLOT_W(SLOT_W)) u_rx_loc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rx_tick),
        .fs_act    (fs_act),
        .hwy_en    (hwy_en),
        .lsb_first (rx_lsb_first),
        .bit_off   (rx_bit_off),
        .slot_off  (rx_slot_off),
        .evt       (rx_evt)
    );

    tdm_tx_lane u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (tx_evt),
        .hwy_en      (hwy_en),
        .mask        (tx_mask),
        .tx_byte     (tx_byte),
        .tx_sd       (tx_sd),
        .tx_oe       (tx_oe),
        .tx_slot_act (tx_slot_act),
        .tx_take     (tx_take)
    );

    tdm_rx_lane u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (rx_evt),
        .sd       (sd_s),
        .hwy_en   (hwy_en),
        .mask     (rx_mask),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/tdm_sel_checker.sv
module tdm_sel_checker (
    input logic clk,
    input logic rst_n,
    input logic hwy_en,
    input logic tx_tick,
    input logic rx_tick,
    input logic tx_sd,
    input logic tx_oe,
    input logic tx_slot_act,
    input logic tx_take,
    input logic rx_valid
);

    assert_oe_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hwy_en && $past(hwy_en) && $past(tx_tick)) |-> (!tx_oe || tx_slot_act));

    assert_quiet_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe |-> !tx_sd);

    assert_no_window_flat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hwy_en && $past(!hwy_en) && $past(tx_tick)) |-> !tx_slot_act);

    assert_steady_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_tick |=> $stable({tx_sd, tx_oe, tx_slot_act}));

    assert_rx_after_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_tick));

    assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_take_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);

    assert_take_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && hwy_en && $past(hwy_en)) |-> tx_slot_act);

endmodule

bind tdm_slot_sel tdm_sel_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hwy_en      (hwy_en),
    .tx_tick     (tx_tick),
    .rx_tick     (rx_tick),
    .tx_sd       (tx_sd),
    .tx_oe       (tx_oe),
    .tx_slot_act (tx_slot_act),
    .tx_take     (tx_take),
    .rx_valid    (rx_valid)
);

// File: tb/tdm_slot_sel_test.sv
module tdm_slot_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hwy_en = 1'b1, fs_pol = 1'b0, edge_inv = 1'b0;
    logic       tx_lsb = 1'b0, rx_lsb = 1'b0;
    logic [2:0] tx_bit = '0, rx_bit = '0;
    logic [5:0] tx_slot = '0, rx_slot = '0;
    logic [7:0] tx_mask = 8'hFF, rx_mask = 8'hFF;
    logic       sclk = 1'b1, fsync = 1'b0, rx_sd = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_sd, tx_oe, tx_slot_act, tx_take, rx_valid;
    logic [7:0] rx_byte;

    int         checks = 0, fails = 0, take_cnt = 0, nh_bits = 0;
    logic [7:0] exp_q[$];
    logic [15:0] lfsr = 16'hACE1;
    string      cur_tag = "R6";

    always #5 clk = ~clk;

    tdm_slot_sel uut (
        .clk(clk), .rst_n(rst_n), .hwy_en(hwy_en), .fs_pol(fs_pol),
        .tx_edge_inv(edge_inv), .rx_edge_inv(edge_inv),
        .tx_lsb_first(tx_lsb), .rx_lsb_first(rx_lsb),
        .tx_bit_off(tx_bit), .tx_slot_off(tx_slot), .tx_mask(tx_mask),
        .rx_bit_off(rx_bit), .rx_slot_off(rx_slot), .rx_mask(rx_mask),
        .sclk(sclk), .fsync(fsync), .rx_sd(rx_sd), .tx_byte(tx_byte),
        .tx_sd(tx_sd), .tx_oe(tx_oe), .tx_slot_act(tx_slot_act),
        .tx_take(tx_take), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard on every received byte, counts takes
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check({cur_tag, " R8 unexpected rx byte"}, 32'(rx_byte), 32'hDEAD);
            end else begin
                check({cur_tag, " R3 R4 rx byte"}, 32'(rx_byte), 32'(exp_q.pop_front()));
            end
        end
        if (rst_n && tx_take) take_cnt++;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        sclk  = ~edge_inv;    // idle on the opposite level of the launch edge
        fsync = fs_pol;       // sync inactive
        wait_clks(5);
        rst_n = 1'b1;
        nh_bits = 0;
        wait_clks(12);
    endtask

    // Driver: runs one frame, predicts tx bits and pushes expected rx bytes
    task automatic run_frame(input int nbits, input logic [7:0] txb);
        int         ts, rs, takes0, exp_takes;
        logic [7:0] racc;
        ts = int'(tx_slot) * 8 + int'(tx_bit);
        rs = int'(rx_slot) * 8 + int'(rx_bit);
        takes0 = take_cnt;
        exp_takes = 0;
        racc = '0;
        tx_byte = txb;
        for (int t = 0; t < nbits; t++) begin
            logic rbit, tw, rw, live, rlive;
            int   ti, ri, tp, rp;
            logic [2:0] tsav;
            rbit = lfsr[0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sclk  = edge_inv;                  // launch edge
            fsync = (t == 0) ^ fs_pol;
            rx_sd = rbit;
            if (hwy_en) begin
                tw = (t >= ts) && (t < ts + 8);  ti = t - ts;
                rw = (t >= rs) && (t < rs + 8);  ri = t - rs;
            end else begin
                tw = 1'b1; ti = nh_bits % 8;
                rw = 1'b1; ri = nh_bits % 8;
            end
            tp = tx_lsb ? ti : 7 - ti;
            rp = rx_lsb ? ri : 7 - ri;
            live  = tw && (!hwy_en || tx_mask[tp & 7]);
            rlive = rw && (!hwy_en || rx_mask[rp & 7]);
            if (tw && ti == 0) exp_takes++;
            wait_clks(8);
            check({cur_tag, " R7 tx_oe"}, 32'(tx_oe), 32'(live));
            check({cur_tag, " R2 R3 R4 tx_sd"}, 32'(tx_sd), live ? 32'(txb[tp & 7]) : 32'd0);
            check({cur_tag, " R6 tx_slot_act"}, 32'(tx_slot_act), 32'(hwy_en && tw));
            tsav = {tx_sd, tx_oe, tx_slot_act};
            if (rw) begin
                if (ri == 0) racc = '0;
                if (rlive) racc[rp & 7] = rbit;
                if (ri == 7) exp_q.push_back(racc);
            end
            sclk = ~edge_inv;                  // sample edge
            wait_clks(8);
            check({cur_tag, " R10 tx steady across sample edge"},
                  32'({tx_sd, tx_oe, tx_slot_act}), 32'(tsav));
            if (!hwy_en) nh_bits++;
        end
        check({cur_tag, " R8 take count"}, 32'(take_cnt - takes0), 32'(exp_takes));
    endtask

    task automatic end_test();
        wait_clks(8);
        check({cur_tag, " R8 pending rx bytes"}, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Reset state (R6, R7)
        do_reset();
        check("R7 reset tx_oe", 32'(tx_oe), 32'd0);
        check("R7 reset tx_sd", 32'(tx_sd), 32'd0);
        check("R6 reset tx_slot_act", 32'(tx_slot_act), 32'd0);
        check("R8 reset rx_valid", 32'(rx_valid), 32'd0);
        check("R8 reset tx_take", 32'(tx_take), 32'd0);

        // R2: whole slot 1, full mask, MSB first
        cur_tag = "R2";
        tx_slot = 6'd1; tx_bit = 3'd0; rx_slot = 6'd1; rx_bit = 3'd0;
        run_frame(24, 8'hA5);
        run_frame(24, 8'h3C);
        end_test();

        // R3 / R4 / R1: sparse masks, mixed bit orders, active-low sync
        cur_tag = "R3";
        fs_pol = 1'b1;
        do_reset();
        tx_slot = 6'd2; tx_bit = 3'd3; tx_mask = 8'h5A; tx_lsb = 1'b1;
        rx_slot = 6'd0; rx_bit = 3'd2; rx_mask = 8'hC3; rx_lsb = 1'b0;
        run_frame(32, 8'hF0);
        cur_tag = "R4";
        tx_lsb = 1'b0; rx_lsb = 1'b1;
        run_frame(32, 8'h96);
        end_test();

        // R5: both edges swapped, slot straddling a slot boundary
        cur_tag = "R5";
        fs_pol = 1'b0; edge_inv = 1'b1;
        do_reset();
        tx_slot = 6'd0; tx_bit = 3'd5; tx_mask = 8'h81; tx_lsb = 1'b0;
        rx_slot = 6'd0; rx_bit = 3'd5; rx_mask = 8'h7E; rx_lsb = 1'b0;
        run_frame(16, 8'hC9);
        run_frame(16, 8'h5E);
        end_test();

        // R1: short frames, counters restart at each sync
        cur_tag = "R1";
        edge_inv = 1'b0;
        do_reset();
        tx_slot = 6'd1; tx_bit = 3'd4; tx_mask = 8'hFF; tx_lsb = 1'b1;
        rx_slot = 6'd1; rx_bit = 3'd4; rx_mask = 8'hFF; rx_lsb = 1'b1;
        run_frame(20, 8'h1B);
        run_frame(20, 8'hE4);
        run_frame(20, 8'h77);
        end_test();

        // R9: streaming mode, sync pulses and partial masks must have no effect
        cur_tag = "R9";
        hwy_en = 1'b0; tx_mask = 8'h0F; rx_mask = 8'h30;
        tx_lsb = 1'b0; rx_lsb = 1'b0;
        do_reset();
        run_frame(16, 8'h6D);
        run_frame(16, 8'hB2);
        end_test();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule